// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

The engine feeds an Ethernet MAC transmitter from a circular ring of transmit descriptors held in a word-addressed memory. Each descriptor takes four 32-bit words on a 16-byte boundary:

| Word | Contents |
| --- | --- |
| 0 | Options and ownership |
| 1 | Buffer byte pointer |
| 2 | Length, and completion status after the send |
| 3 | Byte address of the next descriptor |

The engine checks that it owns the current descriptor and fetches the remaining words. It streams the buffer to the MAC as a byte stream with ready/valid, marking the first and last byte. It then writes back a completion status and hands the descriptor back to software. Last, it follows the next pointer. The descriptor's pad and CRC-append options travel beside the bytes as sideband flags for the serializer.

Software controls the engine through four registers, selected by `reg_addr`:

| Address | Write effect | Read value |
| --- | --- | --- |
| 0 | Sets the ring start | Address of the current descriptor |
| 1 | Bit 0 is the transmit-enable flag | Bit 0 is the transmit-enable flag |
| 2 | Resume strobe | Zero |
| 3 | Write-1-to-clear | Interrupt status |

When the engine finds a descriptor it does not own, it halts and flags that no descriptor is available. A resume write makes it fetch that same descriptor again.

The memory port has a fixed read latency of one cycle. Read data for a request in cycle N is on `mem_rdata` in cycle N+1. Writes complete in the cycle of the request.

Top module: `tx_ring_engine`

## Requirements
- R1: After reset the engine issues no memory request, `tx_valid` and `irq` are low, the status register reads 0 and the current-descriptor readback reads 0.
- R2: Word 0 bit 31 set means the engine owns the descriptor. When the engine fetches word 0 with bit 31 clear, it sends no byte, sets status bit 2 (descriptor unavailable) and halts.
- R3: The frame is `word2[15:0]` bytes long. It starts at byte offset `word1[1:0]` of the word at `word1` and is sent little-endian within each word (byte k of a word is bits 8k+7:8k). `tx_sof` marks the first byte and `tx_eof` marks the last.
- R4: `tx_pad` carries word 0 bit 0 and `tx_crc` carries word 0 bit 1 with every byte of the frame.
- R5: After the last byte is accepted, the engine writes word 2 back with bits 15:0 = length, bit 19 = 1, and bits 31:28 = `tx_coll_cnt` as sampled with the last byte. All other bits are 0.
- R6: After writing word 2, the engine writes word 0 back with bit 31 cleared and bits 30:0 unchanged.
- R7: After the word 0 writeback, the current descriptor becomes the address in word 3 (low 4 bits forced to 0), so a ring whose last entry points to the first wraps around. Register 0 reads the current descriptor address.
- R8: Each completion sets status bit 1, and also sets status bit 0 when word 0 bit 2 is set. Writing 1s to register 3 clears those bits. `irq` is high while any status bit is set.
- R9: A write to register 2 clears the halt, and the engine then fetches the current descriptor again.
- R10: The engine starts a descriptor only while register 1 bit 0 is set. Clearing that bit during a frame lets the frame and its writeback finish, and stops the engine before the next fetch.
- R11: A descriptor of length 0 sends no byte. It is still completed, with word 2 written back as bit 19 set and a collision count of 0.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_data`, `tx_sof` and `tx_eof` hold steady and `tx_valid` stays high.
- R13: A write to register 0 loads the ring start only while the engine is idle. At any other time the write is ignored.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | High while any status bit is set |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the request |
| tx_valid | output | 1 | Byte valid |
| tx_ready | input | 1 | MAC accepts the byte |
| tx_data | output | 8 | Frame byte |
| tx_sof | output | 1 | First byte of the frame |
| tx_eof | output | 1 | Last byte of the frame |
| tx_pad | output | 1 | Pad option of the frame |
| tx_crc | output | 1 | CRC-append option of the frame |
| tx_coll_cnt | input | 4 | Collision count from the MAC, sampled with the last byte |

## Verification
A wrong byte index or buffer word pointer shows up on `tx_data` at the first word boundary the frame crosses. A misplaced first/last flag breaks the framing at the very next byte. A wrong current-descriptor pointer or a missing ownership clear appears within one or two frames. It shows as a wrong readback address, a descriptor sent twice, or a halt that comes too early or never comes. Status bugs show in the status register right after the word 0 writeback.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;

    // descriptor word 0
    localparam int OWN_BIT  = 31;
    localparam int PAD_BIT  = 0;
    localparam int CRC_BIT  = 1;
    localparam int IEN_BIT  = 2;
    // descriptor word 2
    localparam int LEN_W    = 16;
    localparam int DONE_BIT = 19;
    localparam int COLL_LSB = 28;
    localparam int COLL_W   = 4;

    // register map
    localparam logic [1:0] RA_RING   = 2'd0;
    localparam logic [1:0] RA_CTRL   = 2'd1;
    localparam logic [1:0] RA_RESUME = 2'd2;
    localparam logic [1:0] RA_STAT   = 2'd3;

    // status bits
    localparam int ST_IRQ  = 0;
    localparam int ST_DONE = 1;
    localparam int ST_UNAV = 2;
    localparam int ST_W    = 3;

    localparam int LANES = 4;

    typedef enum logic [3:0] {
        S_IDLE, S_RD0, S_RD1, S_RD2, S_RD3, S_RD4,
        S_LOAD, S_LWAIT, S_SEND, S_WB2, S_WB0
    } seq_state_e;

    typedef struct packed {
        logic done;
        logic ien;
        logic unavail;
    } seq_event_t;

    function automatic logic [31:0] status_word(input logic [LEN_W-1:0] len,
                                                input logic [COLL_W-1:0] coll);
        logic [31:0] w;
        w = '0;
        w[LEN_W-1:0] = len;
        w[DONE_BIT] = 1'b1;
        w[COLL_LSB +: COLL_W] = coll;
        return w;
    endfunction

endpackage

// File: rtl/tx_ring_bytesel.sv
module tx_ring_bytesel #(
    parameter int LANES_P = 4,
    localparam int IDX_W = $clog2(LANES_P)
) (
    input  logic [8*LANES_P-1:0] word,
    input  logic [IDX_W-1:0]     idx,
    output logic [7:0]           byte_o
);
    logic [7:0] lane [LANES_P];

    for (genvar g = 0; g < LANES_P; g++) begin : g_lane
        assign lane[g] = word[8*g +: 8];
    end

    assign byte_o = lane[idx];
endmodule

// File: rtl/tx_ring_regs.sv
module tx_ring_regs
    import tx_ring_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [ADDR_W-1:0]  cur_addr,
    input  seq_event_t         ev,
    output logic               tx_on,
    output logic               resume,
    output logic               ring_ld,
    output logic [ADDR_W-5:0]  ring_hi,
    output logic [ST_W-1:0]    stat_q,
    output logic               irq
);
    logic [ST_W-1:0] clr;
    logic [ST_W-1:0] set;
    logic            unused_wdata;

    assign unused_wdata = ^reg_wdata;
    assign ring_ld = reg_wr && (reg_addr == RA_RING);
    assign ring_hi = reg_wdata[ADDR_W-1:4];
    assign resume  = reg_wr && (reg_addr == RA_RESUME);
    assign clr     = (reg_wr && reg_addr == RA_STAT) ? reg_wdata[ST_W-1:0] : '0;

    always_comb begin
        set = '0;
        set[ST_IRQ]  = ev.done && ev.ien;
        set[ST_DONE] = ev.done;
        set[ST_UNAV] = ev.unavail;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_on  <= 1'b0;
            stat_q <= '0;
        end else begin
            if (reg_wr && reg_addr == RA_CTRL) tx_on <= reg_wdata[0];
            stat_q <= (stat_q & ~clr) | set;   // a new event wins over a clear
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_RING: reg_rdata[ADDR_W-1:0] = cur_addr;
            RA_CTRL: reg_rdata[0] = tx_on;
            RA_STAT: reg_rdata[ST_W-1:0] = stat_q;
            default: reg_rdata = '0;
        endcase
    end

    assign irq = |stat_q;
endmodule

// File: rtl/tx_ring_seq.sv
module tx_ring_seq
    import tx_ring_pkg::*;
#(
    parameter int ADDR_W = 16,
    localparam int MW    = ADDR_W - 2,
    localparam int HI_W  = ADDR_W - 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tx_on,
    input  logic               resume,
    input  logic               ring_ld,
    input  logic [HI_W-1:0]    ring_hi,
    output logic [ADDR_W-1:0]  cur_addr,
    output logic               halted,
    output seq_event_t         ev,
    output logic               mem_req,
    output logic               mem_we,
    output logic [MW-1:0]      mem_addr,
    output logic [31:0]        mem_wdata,
    input  logic [31:0]        mem_rdata,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic [7:0]         tx_data,
    output logic               tx_sof,
    output logic               tx_eof,
    output logic               tx_pad,
    output logic               tx_crc,
    input  logic [COLL_W-1:0]  tx_coll_cnt
);
    seq_state_e        state;
    logic [HI_W-1:0]   cur_hi;
    logic [HI_W-1:0]   nxt_hi;
    logic [31:0]       w0_q;
    logic [MW-1:0]     buf_w;
    logic [1:0]        bidx;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  rem;
    logic [31:0]       word_q;
    logic              first;
    logic [COLL_W-1:0] coll_q;
    logic [7:0]        lane_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            cur_hi <= '0;
            nxt_hi <= '0;
            w0_q   <= '0;
            buf_w  <= '0;
            bidx   <= '0;
            len_q  <= '0;
            rem    <= '0;
            word_q <= '0;
            first  <= 1'b0;
            coll_q <= '0;
            halted <= 1'b0;
        end else begin
            if (resume) halted <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (ring_ld) cur_hi <= ring_hi;
                    if (tx_on && !halted) state <= S_RD0;
                end
                S_RD0: state <= S_RD1;
                S_RD1: begin
                    w0_q <= mem_rdata;
                    if (!mem_rdata[OWN_BIT]) begin
                        halted <= 1'b1;
                        state  <= S_IDLE;
                    end else begin
                        state <= S_RD2;
                    end
                end
                S_RD2: begin
                    buf_w <= mem_rdata[ADDR_W-1:2];
                    bidx  <= mem_rdata[1:0];
                    state <= S_RD3;
                end
                S_RD3: begin
                    len_q <= mem_rdata[LEN_W-1:0];
                    rem   <= mem_rdata[LEN_W-1:0];
                    state <= S_RD4;
                end
                S_RD4: begin
                    nxt_hi <= mem_rdata[ADDR_W-1:4];
                    first  <= 1'b1;
                    coll_q <= '0;
                    state  <= (len_q == '0) ? S_WB2 : S_LOAD;
                end
                S_LOAD:  state <= S_LWAIT;
                S_LWAIT: begin
                    word_q <= mem_rdata;
                    state  <= S_SEND;
                end
                S_SEND: begin
                    if (tx_ready) begin
                        first <= 1'b0;
                        rem   <= rem - 1'b1;
                        if (rem == LEN_W'(1)) begin
                            coll_q <= tx_coll_cnt;
                            state  <= S_WB2;
                        end else if (bidx == 2'd3) begin
                            bidx  <= 2'd0;
                            buf_w <= buf_w + 1'b1;
                            state <= S_LOAD;
                        end else begin
                            bidx <= bidx + 1'b1;
                        end
                    end
                end
                S_WB2: state <= S_WB0;
                S_WB0: begin
                    cur_hi <= nxt_hi;
                    state  <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            S_RD0: begin
                mem_req  = 1'b1;
                mem_addr = {cur_hi, 2'd0};
            end
            S_RD1: begin
                mem_req  = mem_rdata[OWN_BIT];
                mem_addr = {cur_hi, 2'd1};
            end
            S_RD2: begin
                mem_req  = 1'b1;
                mem_addr = {cur_hi, 2'd2};
            end
            S_RD3: begin
                mem_req  = 1'b1;
                mem_addr = {cur_hi, 2'd3};
            end
            S_LOAD: begin
                mem_req  = 1'b1;
                mem_addr = buf_w;
            end
            S_WB2: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {cur_hi, 2'd2};
                mem_wdata = status_word(len_q, coll_q);
            end
            S_WB0: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {cur_hi, 2'd0};
                mem_wdata = w0_q & ~(32'd1 << OWN_BIT);
            end
            default: ;
        endcase
    end

    tx_ring_bytesel #(.LANES_P(LANES)) u_sel (
        .word   (word_q),
        .idx    (bidx),
        .byte_o (lane_byte)
    );

    assign tx_valid = (state == S_SEND);
    assign tx_data  = lane_byte;
    assign tx_sof   = tx_valid && first;
    assign tx_eof   = tx_valid && (rem == LEN_W'(1));
    assign tx_pad   = tx_valid && w0_q[PAD_BIT];
    assign tx_crc   = tx_valid && w0_q[CRC_BIT];

    assign ev.done    = (state == S_WB0);
    assign ev.ien     = w0_q[IEN_BIT];
    assign ev.unavail = (state == S_RD1) && !mem_rdata[OWN_BIT];

    assign cur_addr = {cur_hi, 4'b0};
endmodule

// File: rtl/tx_ring_engine.sv
module tx_ring_engine
    import tx_ring_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-3:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_sof,
    output logic              tx_eof,
    output logic              tx_pad,
    output logic              tx_crc,
    input  logic [3:0]        tx_coll_cnt
);
    localparam int HI_W = ADDR_W - 4;

    logic              ctl_on;
    logic              ctl_resume;
    logic              ctl_ring_ld;
    logic [HI_W-1:0]   ctl_ring_hi;
    logic [ADDR_W-1:0] eng_cur;
    logic              eng_halted;
    seq_event_t        eng_ev;
    logic [ST_W-1:0]   stat_q;

    tx_ring_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cur_addr  (eng_cur),
        .ev        (eng_ev),
        .tx_on     (ctl_on),
        .resume    (ctl_resume),
        .ring_ld   (ctl_ring_ld),
        .ring_hi   (ctl_ring_hi),
        .stat_q    (stat_q),
        .irq       (irq)
    );

    tx_ring_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .tx_on       (ctl_on),
        .resume      (ctl_resume),
        .ring_ld     (ctl_ring_ld),
        .ring_hi     (ctl_ring_hi),
        .cur_addr    (eng_cur),
        .halted      (eng_halted),
        .ev          (eng_ev),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready),
        .tx_data     (tx_data),
        .tx_sof      (tx_sof),
        .tx_eof      (tx_eof),
        .tx_pad      (tx_pad),
        .tx_crc      (tx_crc),
        .tx_coll_cnt (tx_coll_cnt)
    );
endmodule

// File: rtl/tx_ring_checker.sv
module tx_ring_checker (
    input logic       clk,
    input logic       rst,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic       tx_sof,
    input logic       tx_eof,
    input logic       mem_req,
    input logic       halted,
    input logic [2:0] stat
);
    logic frame_open;

    always_ff @(posedge clk) begin
        if (rst) frame_open <= 1'b0;
        else if (tx_valid && tx_ready) frame_open <= !tx_eof;
    end

    // R3: a start marker appears exactly when no frame is open
    assert_sof_framing_R3: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (tx_sof == !frame_open));

    // R3: the byte stream and buffer fetches never overlap
    assert_no_fetch_in_send_R3: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !mem_req);

    // R12: a stalled byte stays put
    assert_stall_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof)));

    // R2: a halted engine sends nothing
    assert_halt_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        halted |-> !tx_valid);

    // R2: entering halt raises the unavailable flag
    assert_halt_flag_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(halted) |-> stat[2]);
endmodule

bind tx_ring_engine tx_ring_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .tx_sof   (tx_sof),
    .tx_eof   (tx_eof),
    .mem_req  (mem_req),
    .halted   (eng_halted),
    .stat     (stat_q)
);

// File: tb/tb_tx_ring_engine.sv
module tb_tx_ring_engine;
    localparam int AW = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        mem_req, mem_we;
    logic [AW-3:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        tx_valid, tx_sof, tx_eof, tx_pad, tx_crc;
    logic        tx_ready = 1'b1;
    logic [7:0]  tx_data;
    logic [3:0]  tx_coll_cnt = 4'd0;

    always #4 clk = ~clk;

    tx_ring_engine #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_pad(tx_pad), .tx_crc(tx_crc),
        .tx_coll_cnt(tx_coll_cnt)
    );

    // memory model: buffer bytes equal their byte address (low 8 bits)
    logic [31:0] mem [256];
    logic        tb_wr = 1'b0;
    logic [7:0]  tb_waddr = '0;
    logic [31:0] tb_wdata = '0;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++)
                mem[i] <= {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)};
            mem_rdata <= '0;
        end else begin
            if (tb_wr) mem[tb_waddr] <= tb_wdata;
            if (mem_req) begin
                if (mem_we) mem[mem_addr] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr];
            end
        end
    end

    int  n_chk = 0;
    int  n_fail = 0;
    int  cyc = 0;
    bit  stall = 1'b0;
    bit  finished = 1'b0;

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ready pattern, driven shortly after the edge
    always @(posedge clk) begin
        #1;
        cyc++;
        tx_ready = stall ? ((cyc % 3) != 0) : 1'b1;
    end

    // expected byte stream {pad, crc, sof, eof, data}
    logic [11:0] expq [$];
    logic        pv = 1'b0, pr = 1'b0;
    logic [7:0]  pd = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (pv && !pr)
                chk_eq("R12 stalled byte held", {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, pd});
            if (tx_valid && tx_ready) begin
                if (expq.size() == 0) begin
                    chk_eq("R10 byte sent when none expected", {24'd0, tx_data}, 32'hFFFF_FFFF);
                end else begin
                    logic [11:0] e;
                    e = expq.pop_front();
                    chk_eq("R3 R4 stream byte", {20'd0, tx_pad, tx_crc, tx_sof, tx_eof, tx_data},
                           {20'd0, e});
                end
            end
            pv = tx_valid;
            pr = tx_ready;
            pd = tx_data;
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic poke(input int waddr, input logic [31:0] d);
        @(posedge clk); #1;
        tb_wr = 1'b1; tb_waddr = 8'(waddr); tb_wdata = d;
        @(posedge clk); #1;
        tb_wr = 1'b0;
    endtask

    task automatic set_desc(input int base, input bit own, input logic [2:0] opts,
                            input int bp, input int len, input int nxt);
        poke(base/4,     {own, 28'd0, opts});
        poke(base/4 + 1, 32'(bp));
        poke(base/4 + 2, 32'(len));
        poke(base/4 + 3, 32'(nxt));
    endtask

    task automatic exp_frame(input int bp, input int len, input bit pad, input bit crc);
        for (int k = 0; k < len; k++) begin
            int a;
            logic [31:0] w;
            a = bp + k;
            w = mem[(a >> 2) & 255];
            expq.push_back({pad, crc, (k == 0), (k == len - 1), w[8*(a % 4) +: 8]});
        end
    endtask

    task automatic wait_halt(input string tag);
        logic [31:0] v;
        bit seen;
        seen = 1'b0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            reg_read(2'd3, v);
            seen = v[2];
        end
        if (!seen) chk_eq(tag, 32'd0, 32'd4);
    endtask

    task automatic wait_byte();
        int s;
        s = expq.size();
        for (int i = 0; i < 2000 && expq.size() >= s; i++) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk_eq("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
        chk_eq("R1 mem_req",  {31'd0, mem_req}, 32'd0);
        chk_eq("R1 irq",      {31'd0, irq}, 32'd0);
        reg_read(2'd0, v); chk_eq("R1 current pointer", v, 32'd0);
        reg_read(2'd3, v); chk_eq("R1 status", v, 32'd0);

        // Ring of three with stalls (R2 R3 R4 R5 R6 R7 R8 R12 R13)
        stall = 1'b1;
        tx_coll_cnt = 4'd5;
        set_desc(32'h40, 1, 3'b101, 32'h100, 5, 32'h50);
        set_desc(32'h50, 1, 3'b010, 32'h143, 6, 32'h60);
        set_desc(32'h60, 1, 3'b011, 32'h182, 1, 32'h40);
        exp_frame(32'h100, 5, 1, 0);
        exp_frame(32'h143, 6, 0, 1);
        exp_frame(32'h182, 1, 1, 1);
        reg_write(2'd0, 32'h40);
        reg_write(2'd1, 32'd1);
        wait_byte();
        reg_write(2'd0, 32'h200);           // R13: busy, must be ignored
        wait_halt("R2 halt on unowned descriptor");
        stall = 1'b0;
        chk_eq("R3 all bytes sent", expq.size(), 0);
        chk_eq("R6 word0 desc0", mem[16], 32'h0000_0005);
        chk_eq("R6 word0 desc1", mem[20], 32'h0000_0002);
        chk_eq("R6 word0 desc2", mem[24], 32'h0000_0003);
        chk_eq("R5 word2 desc0", mem[18], 32'h5008_0005);
        chk_eq("R5 word2 desc1", mem[22], 32'h5008_0006);
        chk_eq("R5 word2 desc2", mem[26], 32'h5008_0001);
        reg_read(2'd0, v); chk_eq("R7 R13 wrapped pointer", v, 32'h40);
        reg_read(2'd3, v); chk_eq("R8 status after ring", v, 32'd7);
        chk_eq("R8 irq high", {31'd0, irq}, 32'd1);

        // W1C (R8)
        reg_write(2'd3, 32'd3);
        reg_read(2'd3, v); chk_eq("R8 partial clear", v, 32'd4);
        chk_eq("R8 irq still high", {31'd0, irq}, 32'd1);
        reg_write(2'd3, 32'd4);
        reg_read(2'd3, v); chk_eq("R8 full clear", v, 32'd0);
        chk_eq("R8 irq low", {31'd0, irq}, 32'd0);

        // Resume, unaligned start, no interrupt enable (R9 R8 R3)
        tx_coll_cnt = 4'd0;
        set_desc(32'h40, 1, 3'b010, 32'h1C1, 9, 32'h50);
        exp_frame(32'h1C1, 9, 0, 1);
        reg_write(2'd2, 32'd0);
        wait_halt("R9 resume then halt");
        chk_eq("R9 bytes after resume", expq.size(), 0);
        reg_read(2'd3, v); chk_eq("R8 no irq bit without enable", v, 32'd6);
        reg_read(2'd0, v); chk_eq("R7 next pointer", v, 32'h50);
        chk_eq("R5 word2 resumed", mem[18], 32'h0008_0009);
        reg_write(2'd3, 32'd7);

        // Zero length (R11)
        tx_coll_cnt = 4'hC;
        set_desc(32'h50, 1, 3'b100, 32'h100, 0, 32'h60);
        reg_write(2'd2, 32'd0);
        wait_halt("R11 halt after empty frame");
        reg_read(2'd3, v); chk_eq("R11 completion status", v, 32'd7);
        chk_eq("R11 word2", mem[22], 32'h0008_0000);
        chk_eq("R11 word0", mem[20], 32'h0000_0004);
        reg_read(2'd0, v); chk_eq("R11 pointer advanced", v, 32'h60);
        reg_write(2'd3, 32'd7);

        // Transmit enable gating (R10)
        reg_write(2'd1, 32'd0);
        set_desc(32'h60, 1, 3'b000, 32'h100, 8, 32'h40);
        set_desc(32'h40, 1, 3'b000, 32'h104, 3, 32'h50);
        reg_write(2'd2, 32'd0);
        repeat (40) @(posedge clk);
        reg_read(2'd3, v); chk_eq("R10 disabled: no status", v, 32'd0);
        reg_read(2'd0, v); chk_eq("R10 disabled: pointer", v, 32'h60);
        chk_eq("R10 disabled: still owned", {31'd0, mem[24][31]}, 32'd1);
        exp_frame(32'h100, 8, 0, 0);
        reg_write(2'd1, 32'd1);
        wait_byte();
        reg_write(2'd1, 32'd0);
        repeat (60) @(posedge clk);
        chk_eq("R10 frame finished", expq.size(), 0);
        chk_eq("R10 sent descriptor returned", mem[24], 32'h0000_0000);
        chk_eq("R10 next descriptor untouched", {31'd0, mem[16][31]}, 32'd1);
        chk_eq("R5 collision count", mem[26], 32'hC008_0008);
        reg_read(2'd0, v); chk_eq("R10 stopped at next", v, 32'h40);
        reg_read(2'd3, v); chk_eq("R10 completion only", v, 32'd2);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule